// File: doc/BRIEF.md
# Single-Operand Shift and Modify Unit

This unit takes one register operand, a four-bit operation code and the current T and V flags. It returns the result word and the new flags. It covers five groups of operations:

- bit rotates, including a rotate through T;
- logical and arithmetic right shifts;
- whole-byte shifts;
- the carry-propagating increment, decrement and complement family, plus a plain decrement-and-test;
- byte sign extension.

The register file and the instruction decode sit outside the block. They supply the operand and the flags, and they write back whatever the block returns. When an operation does not change a flag, the block returns the incoming flag value unchanged.

What T means depends on the operation. After decrement-and-test and one's complement, T is a zero detect on the result. After sign extension, T is untouched. After every other defined operation, T takes the carry or the bit shifted out. V is written only by decrement-and-test, increment-with-carry and decrement-with-carry. With the default configuration the outputs are registered one cycle after a valid request.

Top module: `unary_alu`

## Requirements
- R1: Rotate right (code 0) returns {a[0], a[15:1]}. Rotate left (code 1) returns {a[14:0], a[15]}. In both cases T takes the bit that wrapped around.
- R2: Rotate right through T (code 2) returns {T, a[15:1]}, and the new T is a[0].
- R3: Logical right shift (code 3) fills bit 15 with 0. Arithmetic right shift (code 4) copies a[15] into bit 15. Both set T to a[0].
- R4: Byte left shift (code 5) returns {a[7:0], 8'h00} with T = a[8]. Byte right shift (code 6) returns {8'h00, a[15:8]} with T = a[7]. In each case T is the last bit shifted out.
- R5: Decrement-and-test (code 7) returns a-1. T is set when that result is zero. V is set only when a was 16'h8000.
- R6: Increment-with-carry (code 8) returns a+T. Decrement-with-carry (code 9) returns a+16'hFFFF+T. T takes the carry out of bit 15, and V flags signed overflow.
- R7: One's complement (code 10) returns ~a, with T set when the result is zero. Two's complement (code 11) returns ~a+1, and complement-with-carry (code 12) returns ~a+T. For both of these, T takes the carry out of bit 15.
- R8: Sign extension (code 13) copies a[7] into bits 15:8 and keeps bits 7:0. Both flags are returned unchanged.
- R9: Every operation other than codes 7, 8 and 9 returns V equal to the incoming V.
- R10: Codes 14 and 15 return the operand unchanged and return both flags unchanged.
- R11: Reset clears all outputs. A request accepted on a clock edge shows its result, with out_valid high, after that edge. out_valid is low in any cycle that follows an edge with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_a | input | 16 | Operand |
| in_t | input | 1 | Current T flag |
| in_v | input | 1 | Current V flag |
| out_valid | output | 1 | Result strobe |
| out_res | output | 16 | Result word |
| out_t | output | 1 | New T flag |
| out_v | output | 1 | New V flag |

## Verification
The bench probes the sign boundaries:

- 16'h7FFF incremented with T set, and 16'h8000 decremented through either decrement path. A design that took overflow from the carry would miss V here.
- Zero complemented with and without carry in. A design that confused a zero-detect T with a carry T would report the wrong flag.

The byte shifts use operands whose bits 7 and 8 differ, so a design that took T from the wrong end of the byte shows it at once. Sign extension, the reserved codes and the shifts are driven with V high and T set to a value different from the one they would compute. A design that writes either flag when it should not then shows a changed flag at the outputs.

// File: rtl/unary_alu_pkg.sv
package unary_alu_pkg;
   localparam int OP_BITS = 4;

   typedef enum logic [OP_BITS-1:0] {
      OP_RR   = 4'd0,
      OP_RL   = 4'd1,
      OP_RRC  = 4'd2,
      OP_SR   = 4'd3,
      OP_SRA  = 4'd4,
      OP_SLB  = 4'd5,
      OP_SRB  = 4'd6,
      OP_DT   = 4'd7,
      OP_INCC = 4'd8,
      OP_DECC = 4'd9,
      OP_COM  = 4'd10,
      OP_COM2 = 4'd11,
      OP_COMC = 4'd12,
      OP_EXT  = 4'd13
   } op_e;

   // Codes at or below this value go to the shift group.
   localparam logic [OP_BITS-1:0] LAST_SHIFT = 4'd6;
   // Codes above this value are reserved.
   localparam logic [OP_BITS-1:0] LAST_OP    = 4'd13;
endpackage

// File: rtl/unary_alu_shift.sv
module unary_alu_shift
   import unary_alu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [OP_BITS-1:0] op,
   input  logic [W-1:0]       a,
   input  logic               t_in,
   output logic [W-1:0]       res,
   output logic               t_out
);
   localparam int H = W / 2;

   always_comb begin
      res   = a;
      t_out = t_in;
      case (op_e'(op))
         OP_RR: begin
            res   = {a[0], a[W-1:1]};
            t_out = a[0];
         end
         OP_RL: begin
            res   = {a[W-2:0], a[W-1]};
            t_out = a[W-1];
         end
         OP_RRC: begin
            res   = {t_in, a[W-1:1]};
            t_out = a[0];
         end
         OP_SR: begin
            res   = {1'b0, a[W-1:1]};
            t_out = a[0];
         end
         OP_SRA: begin
            res   = {a[W-1], a[W-1:1]};
            t_out = a[0];
         end
         OP_SLB: begin
            res   = {a[H-1:0], {H{1'b0}}};
            t_out = a[H];
         end
         OP_SRB: begin
            res   = {{H{1'b0}}, a[W-1:H]};
            t_out = a[H-1];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/unary_alu_arith.sv
module unary_alu_arith
   import unary_alu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [OP_BITS-1:0] op,
   input  logic [W-1:0]       a,
   input  logic               t_in,
   input  logic               v_in,
   output logic [W-1:0]       res,
   output logic               t_out,
   output logic               v_out
);
   localparam int H = W / 2;
   localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] dec_one;
   logic [W:0]   inc_sum, dec_sum, neg_sum, comc_sum;

   assign dec_one  = a - W'(1);
   assign inc_sum  = {1'b0, a} + {{W{1'b0}}, t_in};
   assign dec_sum  = {1'b0, a} + {1'b0, {W{1'b1}}} + {{W{1'b0}}, t_in};
   assign neg_sum  = {1'b0, ~a} + {{W{1'b0}}, 1'b1};
   assign comc_sum = {1'b0, ~a} + {{W{1'b0}}, t_in};

   always_comb begin
      res   = a;
      t_out = t_in;
      v_out = v_in;
      case (op_e'(op))
         OP_DT: begin
            res   = dec_one;
            t_out = (dec_one == '0);
            v_out = (a == MIN_NEG);
         end
         OP_INCC: begin
            res   = inc_sum[W-1:0];
            t_out = inc_sum[W];
            v_out = ~a[W-1] & inc_sum[W-1];
         end
         OP_DECC: begin
            res   = dec_sum[W-1:0];
            t_out = dec_sum[W];
            v_out = a[W-1] & ~dec_sum[W-1];
         end
         OP_COM: begin
            res   = ~a;
            t_out = (~a == '0);
         end
         OP_COM2: begin
            res   = neg_sum[W-1:0];
            t_out = neg_sum[W];
         end
         OP_COMC: begin
            res   = comc_sum[W-1:0];
            t_out = comc_sum[W];
         end
         OP_EXT: res = {{H{a[H-1]}}, a[H-1:0]};
         default: ;
      endcase
   end
endmodule

// File: rtl/unary_alu.sv
module unary_alu
   import unary_alu_pkg::*;
#(
   parameter int W       = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [OP_BITS-1:0] in_op,
   input  logic [W-1:0]       in_a,
   input  logic               in_t,
   input  logic               in_v,
   output logic               out_valid,
   output logic [W-1:0]       out_res,
   output logic               out_t,
   output logic               out_v
);
   if (W < 4 || (W % 2) != 0) begin : g_bad_width
      $error("unary_alu: W must be even and at least 4");
   end

   logic [W-1:0] sh_res, ar_res, nx_res;
   logic         sh_t, ar_t, ar_v, nx_t, nx_v;

   unary_alu_shift #(.W(W)) u_shift (
      .op(in_op), .a(in_a), .t_in(in_t), .res(sh_res), .t_out(sh_t)
   );

   unary_alu_arith #(.W(W)) u_arith (
      .op(in_op), .a(in_a), .t_in(in_t), .v_in(in_v),
      .res(ar_res), .t_out(ar_t), .v_out(ar_v)
   );

   always_comb begin
      if (in_op <= LAST_SHIFT) begin
         nx_res = sh_res;
         nx_t   = sh_t;
         nx_v   = in_v;
      end else if (in_op <= LAST_OP) begin
         nx_res = ar_res;
         nx_t   = ar_t;
         nx_v   = ar_v;
      end else begin
         nx_res = in_a;
         nx_t   = in_t;
         nx_v   = in_v;
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
            out_t     <= 1'b0;
            out_v     <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_res <= nx_res;
               out_t   <= nx_t;
               out_v   <= nx_v;
            end
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_res   = nx_res;
      assign out_t     = nx_t;
      assign out_v     = nx_v;
   end
endmodule

// File: rtl/unary_alu_chk.sv
module unary_alu_chk
   import unary_alu_pkg::*;
#(
   parameter int W       = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [OP_BITS-1:0] in_op,
   input logic [W-1:0]       in_a,
   input logic               in_t,
   input logic               in_v,
   input logic               out_valid,
   input logic [W-1:0]       out_res,
   input logic               out_t,
   input logic               out_v
);
   localparam int H = W / 2;

   if (REG_OUT) begin : g_props
      p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> out_valid == $past(in_valid));

      p_rr_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op == OP_RR) |=> out_t == out_res[W-1]);

      p_dt_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op == OP_DT) |=> out_t == (out_res == '0));

      p_com_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op == OP_COM) |=> out_t == (out_res == '0));

      p_ext_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op == OP_EXT) |=>
            (out_t == $past(in_t) && out_v == $past(in_v)
             && out_res[H-1:0] == $past(in_a[H-1:0])));

      p_v_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op != OP_DT && in_op != OP_INCC && in_op != OP_DECC)
            |=> out_v == $past(in_v));

      p_rsvd_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op > LAST_OP) |=> out_res == $past(in_a));
   end
endmodule

bind unary_alu unary_alu_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
   .in_a(in_a), .in_t(in_t), .in_v(in_v), .out_valid(out_valid),
   .out_res(out_res), .out_t(out_t), .out_v(out_v)
);

// File: tb/test_unary_alu.sv
`timescale 1ns/1ps
module test_unary_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  in_op = '0;
   logic [15:0] in_a = '0;
   logic        in_t = 1'b0;
   logic        in_v = 1'b0;
   logic        out_valid, out_t, out_v;
   logic [15:0] out_res;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   unary_alu i_unary_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_t(in_t), .in_v(in_v), .out_valid(out_valid),
      .out_res(out_res), .out_t(out_t), .out_v(out_v)
   );

   task automatic chk(string tag, logic [15:0] er, logic et, logic ev);
      total++;
      if (out_valid !== 1'b1 || out_res !== er || out_t !== et || out_v !== ev) begin
         bad++;
         $display("FAIL %s: got valid=%b res=%h t=%b v=%b, expected valid=1 res=%h t=%b v=%b",
                  tag, out_valid, out_res, out_t, out_v, er, et, ev);
      end
   endtask

   // Apply one request, then check the registered result after the capturing edge.
   task automatic run(string tag, logic [3:0] op, logic [15:0] a, logic t, logic v,
                      logic [15:0] er, logic et, logic ev);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_a = a; in_t = t; in_v = v;
      @(negedge clk);
      in_valid = 1'b0;
      chk(tag, er, et, ev);
   endtask

   task automatic t_reset();
      total++;
      if (out_valid !== 1'b0 || out_res !== 16'h0 || out_t !== 1'b0 || out_v !== 1'b0) begin
         bad++;
         $display("FAIL R11 reset: got valid=%b res=%h t=%b v=%b, expected 0 0000 0 0",
                  out_valid, out_res, out_t, out_v);
      end
   endtask

   task automatic t_rotates();
      run("R1 RR wrap",   4'd0, 16'h8001, 1'b0, 1'b1, 16'hC000, 1'b1, 1'b1);
      run("R1 RR plain",  4'd0, 16'h0002, 1'b1, 1'b0, 16'h0001, 1'b0, 1'b0);
      run("R1 RL wrap",   4'd1, 16'h8001, 1'b0, 1'b0, 16'h0003, 1'b1, 1'b0);
      run("R2 RRC out",   4'd2, 16'h0001, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0);
      run("R2 RRC in",    4'd2, 16'h0000, 1'b1, 1'b1, 16'h8000, 1'b0, 1'b1);
   endtask

   task automatic t_shifts();
      run("R3 SR",        4'd3, 16'h8003, 1'b0, 1'b0, 16'h4001, 1'b1, 1'b0);
      run("R3 SRA",       4'd4, 16'h8002, 1'b1, 1'b1, 16'hC001, 1'b0, 1'b1);
      run("R4 SLB bit8=0",4'd5, 16'h1234, 1'b1, 1'b0, 16'h3400, 1'b0, 1'b0);
      run("R4 SLB bit8=1",4'd5, 16'h0100, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0);
      run("R4 SRB bit7=1",4'd6, 16'h1280, 1'b0, 1'b1, 16'h0012, 1'b1, 1'b1);
   endtask

   task automatic t_decrement_test();
      run("R5 DT to zero",  4'd7, 16'h0001, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0);
      run("R5 DT underflow",4'd7, 16'h8000, 1'b1, 1'b0, 16'h7FFF, 1'b0, 1'b1);
      run("R5 DT wrap",     4'd7, 16'h0000, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0);
   endtask

   task automatic t_carry_chain();
      run("R6 INCC overflow", 4'd8, 16'h7FFF, 1'b1, 1'b0, 16'h8000, 1'b0, 1'b1);
      run("R6 INCC carry",    4'd8, 16'hFFFF, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0);
      run("R6 INCC no T",     4'd8, 16'h1234, 1'b0, 1'b1, 16'h1234, 1'b0, 1'b0);
      run("R6 DECC underflow",4'd9, 16'h8000, 1'b0, 1'b0, 16'h7FFF, 1'b1, 1'b1);
      run("R6 DECC borrow",   4'd9, 16'h0000, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0);
      run("R6 DECC T set",    4'd9, 16'h0005, 1'b1, 1'b1, 16'h0005, 1'b1, 1'b0);
   endtask

   task automatic t_complements();
      run("R7 COM zero",     4'd10, 16'hFFFF, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b1);
      run("R7 COM nonzero",  4'd10, 16'h00FF, 1'b1, 1'b0, 16'hFF00, 1'b0, 1'b0);
      run("R7 COM2 zero",    4'd11, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b1);
      run("R7 COM2 one",     4'd11, 16'h0001, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0);
      run("R7 COMC carry",   4'd12, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0);
      run("R7 COMC no T",    4'd12, 16'h0000, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b1);
      run("R7 COMC mixed",   4'd12, 16'h0F0F, 1'b1, 1'b0, 16'hF0F1, 1'b0, 1'b0);
   endtask

   task automatic t_extend();
      run("R8 EXT negative", 4'd13, 16'h0080, 1'b1, 1'b0, 16'hFF80, 1'b1, 1'b0);
      run("R8 EXT positive", 4'd13, 16'hFF7F, 1'b0, 1'b1, 16'h007F, 1'b0, 1'b1);
   endtask

   task automatic t_v_hold();
      run("R9 V kept by SLB", 4'd5, 16'h00FF, 1'b0, 1'b1, 16'hFF00, 1'b0, 1'b1);
      run("R9 V kept by COM2",4'd11, 16'h8000, 1'b0, 1'b1, 16'h8000, 1'b0, 1'b1);
   endtask

   task automatic t_reserved();
      run("R10 code 14", 4'd14, 16'hBEEF, 1'b1, 1'b1, 16'hBEEF, 1'b1, 1'b1);
      run("R10 code 15", 4'd15, 16'h1357, 1'b0, 1'b0, 16'h1357, 1'b0, 1'b0);
   endtask

   task automatic t_idle();
      run("R11 before idle", 4'd0, 16'h0004, 1'b0, 1'b0, 16'h0002, 1'b0, 1'b0);
      @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin
         bad++;
         $display("FAIL R11 idle valid: got %b, expected 0", out_valid);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_rotates();
      t_shifts();
      t_decrement_test();
      t_carry_chain();
      t_complements();
      t_extend();
      t_v_hold();
      t_reserved();
      t_idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule